// File: doc/BRIEF.md
# QPSK Differential Decoder and Serializer

This block sits behind an equalizer in a QPSK receiver. The equalizer delivers one hard decision per symbol: the sign of I and the sign of Q, marked by a one-cycle strobe. The block turns the two signs into a quadrant. It then takes the rotation from the quadrant of the previous symbol and maps that rotation to the bit pair the transmitter encoded. Because only the change between symbols carries data, the receiver does not need to resolve the absolute carrier phase.

Each decoded pair is sent out on one serial data line at two bits per symbol, together with a bit clock made from the system clock. A mode input selects the mapping for a spectrally inverted IF, in which the roles of +90 and -90 degrees are exchanged. A valid output is qualified by an external lock input, so downstream logic accepts bits only while the upstream loops are locked. The valid output is also held low for the first symbol after reset, because that symbol has no true predecessor.

Strobes are assumed to be at least `4*HALF_BIT_CYC` clock cycles apart. A strobe restarts the bit timing.

Top module: `qpsk_diff_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears. After that edge `ser_data` is 0, `bit_clk` is 1 and `ser_valid` is 0.
- R2: The quadrant is computed from the sign bits `{dec_i,dec_q}`: 00 is 0, 01 is 1 (+90 deg), 11 is 2 (180 deg) and 10 is 3 (270 deg). The rotation is (new minus previous) modulo 4. With `inv_mode`=0, the pair codes are: rotation 0 gives 00, rotation 1 (+90) gives 10, rotation 3 (-90) gives 01, and rotation 2 gives 11.
- R3: With `inv_mode`=1, rotation 1 gives 01 and rotation 3 gives 10. Rotations 0 and 2 give the same codes as in R2.
- R4: The left bit of the pair code is sent first, for `2*HALF_BIT_CYC` cycles. The right bit follows for the next `2*HALF_BIT_CYC` cycles.
- R5: Within each bit interval, `bit_clk` is low for the first `HALF_BIT_CYC` cycles and high for the rest. It falls in the cycle in which `ser_data` changes and changes at no other time.
- R6: After reset the previous quadrant is 0. The first symbol after reset is decoded against 0, but `ser_valid` stays low while that symbol is shifted out.
- R7: `ser_valid` is high only while `lock_in` is high and a symbol other than the first after reset is being shifted out.
- R8: When `4*HALF_BIT_CYC` cycles pass with no new strobe, the line goes idle: `bit_clk` stays high, `ser_data` holds the last bit, and `ser_valid` is 0.
- R9: The first bit of a symbol appears on `ser_data` in the cycle after its strobe, which is well under six bit times.
- R10: A symbol that arrives while `lock_in` is low is still decoded, and it becomes the reference quadrant for the next symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_stb | input | 1 | One-cycle strobe marking a new decision |
| dec_i | input | 1 | Sign decision of I (1 = negative) |
| dec_q | input | 1 | Sign decision of Q (1 = negative) |
| inv_mode | input | 1 | 1 selects the mapping for an inverted spectrum |
| lock_in | input | 1 | Upstream lock indication |
| ser_data | output | 1 | Serial decoded data |
| bit_clk | output | 1 | Recovered bit clock; data changes on its falling edge |
| ser_valid | output | 1 | Data on `ser_data` is valid |

## Verification
On every cycle, the assertions check the shape of the bit timing. Data may change only at a bit boundary, and the bit clock may move only at half-bit steps. They also check the reset values, the idle state after a symbol ends, the low start of the clock after each strobe, and the suppressed valid for the first symbol after reset. The mapping itself can only be shown by the bench's scenarios. These cover all sixteen pairs of previous and new quadrant in both modes, symbols decoded while unlocked that set the reference for later ones, and a reset in the middle of a run.

// File: rtl/dq_pkg.sv
// Package: shared types and the decoding functions for the differential
// QPSK decoder. Assumes sign bits are 1 for a negative value.
package dq_pkg;

    typedef logic [1:0] quad_t;   // quadrant index, counted in +90 degree steps
    typedef logic [1:0] pair_t;   // decoded bit pair, bit 1 is sent first

    // Gray-ordered map from the sign bits to a quadrant index
    function automatic quad_t quad_of(input logic s_i, input logic s_q);
        quad_t r;
        case ({s_i, s_q})
            2'b00:   r = 2'd0;
            2'b01:   r = 2'd1;
            2'b11:   r = 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

    // Map a rotation (in +90 degree steps, modulo 4) to a bit pair
    function automatic pair_t pair_of(input quad_t rot, input logic inv);
        pair_t r;
        case (rot)
            2'd0:    r = 2'b00;
            2'd1:    r = inv ? 2'b01 : 2'b10;
            2'd2:    r = 2'b11;
            default: r = inv ? 2'b10 : 2'b01;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dq_rot_decode.sv
// Rotation decoder: holds the quadrant of the previous symbol and turns
// the rotation to the current decision into a bit pair. Assumes stb is a
// one-cycle pulse. The output is combinational and is valid in the strobe cycle.
module dq_rot_decode
    import dq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stb,
    input  logic  s_i,
    input  logic  s_q,
    input  logic  inv,
    output pair_t pair_o,
    output logic  first_o
);

    quad_t prev_q;
    quad_t cur_quad;
    quad_t rot;
    logic  first_q;

    // Form the quadrant, the rotation and the pair for the present decision
    always_comb begin
        cur_quad = quad_of(s_i, s_q);
        rot      = cur_quad - prev_q;
        pair_o   = pair_of(rot, inv);
        first_o  = first_q;
    end

    // Keep the reference quadrant and the first-symbol flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 2'd0;
            first_q <= 1'b1;
        end else if (stb) begin
            prev_q  <= cur_quad;
            first_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dq_bit_shifter.sv
// Bit shifter: sends a two-bit pair on one line with a bit clock that is
// derived from a phase counter. Assumes loads are at least 4*HALF_BIT_CYC
// cycles apart. All outputs are registered.
module dq_bit_shifter
    import dq_pkg::*;
#(
    parameter int HALF_BIT_CYC = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  pair_t pair_in,
    input  logic  pair_ok,
    output logic  ser_o,
    output logic  bclk_o,
    output logic  busy_o,
    output logic  ok_o
);

    localparam int SYM_CYC = 4 * HALF_BIT_CYC;
    localparam int CW      = $clog2(SYM_CYC + 1);
    localparam logic [CW-1:0] IDLE_V = CW'(SYM_CYC);
    localparam logic [CW-1:0] BIT_V  = CW'(2 * HALF_BIT_CYC);
    localparam logic [CW-1:0] HALF_V = CW'(HALF_BIT_CYC);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    pair_t         pair_q;
    pair_t         pair_nxt;
    logic          second_bit;
    logic          hi_half;

    // Next phase count, the pair to hold and the timing decode of the next count
    always_comb begin
        if (load)
            cnt_nxt = '0;
        else if (cnt_q == IDLE_V)
            cnt_nxt = IDLE_V;
        else
            cnt_nxt = cnt_q + 1'b1;
        pair_nxt   = load ? pair_in : pair_q;
        second_bit = (cnt_nxt >= BIT_V);
        hi_half    = (cnt_nxt == IDLE_V) || ((cnt_nxt % BIT_V) >= HALF_V);
    end

    // Advance the phase and register the line outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= IDLE_V;
            pair_q <= 2'b00;
            ser_o  <= 1'b0;
            bclk_o <= 1'b1;
            busy_o <= 1'b0;
            ok_o   <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            pair_q <= pair_nxt;
            ser_o  <= second_bit ? pair_nxt[0] : pair_nxt[1];
            bclk_o <= hi_half;
            busy_o <= (cnt_nxt != IDLE_V);
            if (load)
                ok_o <= pair_ok;
        end
    end

endmodule

// File: rtl/qpsk_diff_serializer.sv
// Top: a differential QPSK decoder followed by a two-bit serializer.
// Assumes sym_stb pulses are at least 4*HALF_BIT_CYC cycles apart.
// The valid output follows lock_in in the same cycle.
module qpsk_diff_serializer
    import dq_pkg::*;
#(
    parameter int HALF_BIT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_stb,
    input  logic dec_i,
    input  logic dec_q,
    input  logic inv_mode,
    input  logic lock_in,
    output logic ser_data,
    output logic bit_clk,
    output logic ser_valid
);

    pair_t dec_pair;
    logic  dec_first;
    logic  sh_busy;
    logic  sh_ok;

    dq_rot_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (sym_stb),
        .s_i     (dec_i),
        .s_q     (dec_q),
        .inv     (inv_mode),
        .pair_o  (dec_pair),
        .first_o (dec_first)
    );

    dq_bit_shifter #(.HALF_BIT_CYC(HALF_BIT_CYC)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sym_stb),
        .pair_in (dec_pair),
        .pair_ok (!dec_first),
        .ser_o   (ser_data),
        .bclk_o  (bit_clk),
        .busy_o  (sh_busy),
        .ok_o    (sh_ok)
    );

    // Qualify the outgoing bits with the shifter state and the lock input
    always_comb begin
        ser_valid = sh_ok && sh_busy && lock_in;
    end

endmodule

// File: rtl/qpsk_diff_serializer_chk.sv
// Checker: timing properties of the serial line, tracked against its own
// count of cycles since the last strobe. It is bound into the top module.
module qpsk_diff_serializer_chk #(
    parameter int HALF_BIT_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sym_stb,
    input logic ser_data,
    input logic bit_clk,
    input logic ser_valid
);

    localparam int SYM_CYC = 4 * HALF_BIT_CYC;

    int   since_stb;
    logic seen_stb;

    // Count the cycles since the last strobe, saturating when the line is idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_stb <= SYM_CYC;
            seen_stb  <= 1'b0;
        end else begin
            if (sym_stb) since_stb <= 0;
            else if (since_stb < SYM_CYC) since_stb <= since_stb + 1;
            if (sym_stb) seen_stb <= 1'b1;
        end
    end

    a_r1_reset_values: assert property (@(posedge clk)
        !rst_n |=> (bit_clk && !ser_data && !ser_valid));

    a_r4_data_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(ser_data) |-> (since_stb == 0 || since_stb == 2 * HALF_BIT_CYC));

    a_r5_clk_half_steps: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(bit_clk) |-> ((since_stb % HALF_BIT_CYC) == 0));

    a_r5_fall_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(ser_data) |-> !bit_clk);

    a_r6_first_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && !seen_stb) |=> !ser_valid);

    a_r8_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        (since_stb == SYM_CYC) |-> (bit_clk && !ser_valid));

    a_r9_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |=> !bit_clk);

endmodule

bind qpsk_diff_serializer qpsk_diff_serializer_chk #(.HALF_BIT_CYC(HALF_BIT_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_stb   (sym_stb),
    .ser_data  (ser_data),
    .bit_clk   (bit_clk),
    .ser_valid (ser_valid)
);

// File: tb/qpsk_diff_serializer_bench.sv
`timescale 1ns/1ps
module qpsk_diff_serializer_bench;

    localparam int HB  = 2;
    localparam int SYM = 4 * HB;

    logic clk = 1'b0;
    logic rst_n, sym_stb, dec_i, dec_q, inv_mode, lock_in;
    logic ser_data, bit_clk, ser_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit [1:0] prev_quad;
    bit first_sym;

    always #2.5 clk = ~clk;

    qpsk_diff_serializer #(.HALF_BIT_CYC(HB)) u_qpsk_diff_serializer (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .dec_i(dec_i), .dec_q(dec_q),
        .inv_mode(inv_mode), .lock_in(lock_in),
        .ser_data(ser_data), .bit_clk(bit_clk), .ser_valid(ser_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Gray quadrant from the sign bits, as stated in R2
    function automatic bit [1:0] quad_ref(input bit si, input bit sq);
        if (!si) return sq ? 2'd1 : 2'd0;
        return sq ? 2'd2 : 2'd3;
    endfunction

    // Pair code from the rotation, as stated in R2 and R3
    function automatic bit [1:0] pair_ref(input bit [1:0] rot, input bit inv);
        if (rot == 2'd0) return 2'b00;
        if (rot == 2'd2) return 2'b11;
        if (rot == 2'd1) return inv ? 2'b01 : 2'b10;
        return inv ? 2'b10 : 2'b01;
    endfunction

    // Send one symbol at the current negedge and check every cycle it is shifted out
    task automatic send(input bit [1:0] quad, input bit inv, input bit lk, input int extra);
        bit [1:0] p;
        bit si, sq, ev, ec, ed;
        si = (quad == 2'd2) || (quad == 2'd3);
        sq = (quad == 2'd1) || (quad == 2'd2);
        p  = pair_ref(quad_ref(si, sq) - prev_quad, inv);
        sym_stb = 1'b1; dec_i = si; dec_q = sq; inv_mode = inv; lock_in = lk;
        @(negedge clk);
        sym_stb = 1'b0;
        for (int k = 0; k < SYM + extra; k++) begin
            ec = (k >= SYM) ? 1'b1 : ((k % (2 * HB)) >= HB);
            ed = (k >= 2 * HB) ? p[0] : p[1];
            ev = (k < SYM) && lk && !first_sym;
            if (k == 0)
                chk(ser_data == ed, "R9 first bit next cycle", ser_data, ed);
            else if (k >= SYM)
                chk(ser_data == ed, "R8 idle data hold", ser_data, ed);
            else if (k < 2 * HB)
                chk(ser_data == ed, inv ? "R3 R4 left bit" : "R2 R4 left bit", ser_data, ed);
            else
                chk(ser_data == ed, inv ? "R3 R4 right bit" : "R2 R4 right bit", ser_data, ed);
            chk(bit_clk == ec, (k >= SYM) ? "R8 idle clock" : "R5 bit clock", bit_clk, ec);
            chk(ser_valid == ev, first_sym ? "R6 first symbol invalid" : "R7 valid", ser_valid, ev);
            if (k < SYM + extra - 1) @(negedge clk);
        end
        prev_quad = quad;
        first_sym = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(bit_clk == 1'b1,   "R1 reset clock", bit_clk, 1);
        chk(ser_data == 1'b0,  "R1 reset data", ser_data, 0);
        chk(ser_valid == 1'b0, "R1 reset valid", ser_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        prev_quad = 2'd0;
        first_sym = 1;
    endtask

    initial begin
        rst_n = 1'b0; sym_stb = 1'b0; dec_i = 1'b0; dec_q = 1'b0;
        inv_mode = 1'b0; lock_in = 1'b0;
        @(negedge clk);
        do_reset();
        // R6: first symbol is decoded against quadrant 0 and flagged invalid
        send(2'd2, 1'b0, 1'b1, 0);
        // R2 and R3: every previous/new quadrant pair in both modes
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++) begin
                    send(2'(a), 1'(m), 1'b1, 0);
                    send(2'(b), 1'(m), 1'b1, 0);
                end
        // R10: unlocked symbols still set the reference
        send(2'd1, 1'b0, 1'b0, 0);
        send(2'd3, 1'b1, 1'b0, 0);
        send(2'd0, 1'b0, 1'b1, 0);
        // R8: idle after a symbol with no new strobe
        send(2'd3, 1'b0, 1'b1, 4);
        // R1 and R6: reset during a run, then the first symbol again
        send(2'd1, 1'b1, 1'b1, 0);
        do_reset();
        send(2'd3, 1'b1, 1'b1, 0);
        send(2'd0, 1'b1, 1'b1, 2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule